// File: doc/BRIEF.md
# Configurable Multiply-Add Tile Unit

This block is the arithmetic core of one tile in an array of reconfigurable compute tiles. It holds a 16-bit multiplier and a 16-bit adder and, under configuration, produces a sum, a product or a fused product-plus-addend. Each of its three operands is chosen independently. The source can be a value written into the tile's configuration, one of several 16-bit routing buses entering the tile, or a constant fixed at design time.

The tile does not work at the full main-clock rate. A configurable divider issues a result-update strobe once every N main-clock cycles. A separate slow failsafe clock flips the polarity of the fixed constants. A tile set to draw its operands from the toggling constants therefore produces switching activity with no external stimulus, which supports activity and heat studies on the array.

Top module: `mac_tile`

## Requirements
- R1: While `rst_ni` is low, `res_o` is 0 and `res_valid_o` is 0. The toggle phase of the constants returns to "true" (constant unchanged).
- R2: With op code 2'b00 the result is (A + B) mod 2^16.
- R3: With op code 2'b01 the result is the low 16 bits of A * B.
- R4: With op code 2'b10 the result is (A * B + C) mod 2^16.
- R5: With op code 2'b11 a strobe leaves `res_o` unchanged.
- R6: Each operand's 2-bit source code selects as follows. 2'b00 selects its configured register value. 2'b01 selects routing bus k, where k is the operand's bus index and bus k occupies `bus_i[16k+15:16k]`. 2'b10 selects its fixed constant (A: KA, B: KB, C: KC).
- R7: Source code 2'b11 selects the fixed constant XORed with the toggle phase. After reset this gives the constant itself. Each rising edge of `fs_clk_i` inverts the phase, and the inversion is visible to the datapath within three main-clock cycles.
- R8: With divider field d, the strobe fires once every d+1 main-clock cycles. The operands and op are sampled on a strobe edge. `res_o` takes the new value and `res_valid_o` is high for exactly the following cycle, and `res_o` changes at no other time.
- R9: A bus index that names no existing bus (3 when there are three buses) gives the operand the value 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| fs_clk_i | input | 1 | Failsafe clock that toggles the constant phase |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_div_i | input | DIVW | Divider field d; strobe period is d+1 cycles |
| cfg_op_i | input | 2 | Operation: 00 add, 01 multiply, 10 multiply-add, 11 hold |
| cfg_src_a_i | input | 2 | Source code of operand A |
| cfg_src_b_i | input | 2 | Source code of operand B |
| cfg_src_c_i | input | 2 | Source code of operand C |
| cfg_bsel_a_i | input | BSELW | Bus index of operand A |
| cfg_bsel_b_i | input | BSELW | Bus index of operand B |
| cfg_bsel_c_i | input | BSELW | Bus index of operand C |
| cfg_reg_a_i | input | W | Configured value of operand A |
| cfg_reg_b_i | input | W | Configured value of operand B |
| cfg_reg_c_i | input | W | Configured value of operand C |
| bus_i | input | NBUS*W | Routing buses, bus k in slice k |
| res_o | output | W | Registered result |
| res_valid_o | output | 1 | High for one cycle after each strobe |

## Verification
The properties assume the configuration inputs are quasi-static: they change only between strobes and never in the same cycle as the divider field is checked against. The arithmetic properties compare the result with the operands as sampled one cycle earlier, so they depend on register-sourced operands staying put across that cycle. The bench changes every configuration field only at the falling edge of the main clock and then waits for a strobe that follows the change. It raises `fs_clk_i` only while the datapath is idle, well apart from any strobe, so the crossing of the toggle phase never coincides with a result update.

// File: rtl/mac_tile.sv
module mac_tile #(
  parameter int          W     = 16,
  parameter int          NBUS  = 3,
  parameter int          DIVW  = 4,
  parameter int          BSELW = (NBUS > 1) ? $clog2(NBUS + 1) : 1,
  parameter logic [W-1:0] KA   = 16'h00A5,
  parameter logic [W-1:0] KB   = 16'h0003,
  parameter logic [W-1:0] KC   = 16'h0100
) (
  input  logic              clk_i,
  input  logic              fs_clk_i,
  input  logic              rst_ni,
  input  logic [DIVW-1:0]   cfg_div_i,
  input  logic [1:0]        cfg_op_i,
  input  logic [1:0]        cfg_src_a_i,
  input  logic [1:0]        cfg_src_b_i,
  input  logic [1:0]        cfg_src_c_i,
  input  logic [BSELW-1:0]  cfg_bsel_a_i,
  input  logic [BSELW-1:0]  cfg_bsel_b_i,
  input  logic [BSELW-1:0]  cfg_bsel_c_i,
  input  logic [W-1:0]      cfg_reg_a_i,
  input  logic [W-1:0]      cfg_reg_b_i,
  input  logic [W-1:0]      cfg_reg_c_i,
  input  logic [NBUS*W-1:0] bus_i,
  output logic [W-1:0]      res_o,
  output logic              res_valid_o
);

  logic            tog_q, tog_m, tog_s;
  logic [DIVW-1:0] cnt_q;
  logic            tick;
  logic [W-1:0]    opa, opb, opc, prod, nxt;

  function automatic logic [W-1:0] pick(
    input logic [1:0]        src,
    input logic [BSELW-1:0]  sel,
    input logic [W-1:0]      rv,
    input logic [W-1:0]      k,
    input logic [NBUS*W-1:0] buses,
    input logic              ph
  );
    logic [W-1:0] b;
    b = '0;
    for (int i = 0; i < NBUS; i++)
      if (sel == BSELW'(i)) b = buses[i*W +: W];
    case (src)
      2'b00:   return rv;
      2'b01:   return b;
      2'b10:   return k;
      default: return k ^ {W{ph}};
    endcase
  endfunction

  always_ff @(posedge fs_clk_i or negedge rst_ni)
    if (!rst_ni) tog_q <= 1'b0;
    else         tog_q <= ~tog_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      tog_m <= 1'b0;
      tog_s <= 1'b0;
    end else begin
      tog_m <= tog_q;
      tog_s <= tog_m;
    end

  assign tick = (cnt_q >= cfg_div_i);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= tick ? '0 : cnt_q + DIVW'(1);

  assign opa  = pick(cfg_src_a_i, cfg_bsel_a_i, cfg_reg_a_i, KA, bus_i, tog_s);
  assign opb  = pick(cfg_src_b_i, cfg_bsel_b_i, cfg_reg_b_i, KB, bus_i, tog_s);
  assign opc  = pick(cfg_src_c_i, cfg_bsel_c_i, cfg_reg_c_i, KC, bus_i, tog_s);
  assign prod = opa * opb;

  always_comb
    case (cfg_op_i)
      2'b00:   nxt = opa + opb;
      2'b01:   nxt = prod;
      2'b10:   nxt = prod + opc;
      default: nxt = res_o;
    endcase

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      res_o       <= '0;
      res_valid_o <= 1'b0;
    end else begin
      res_valid_o <= tick;
      if (tick) res_o <= nxt;
    end

endmodule

module mac_tile_chk #(
  parameter int W    = 16,
  parameter int DIVW = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [DIVW-1:0] cfg_div_i,
  input logic [1:0]      cfg_op_i,
  input logic [1:0]      cfg_src_a_i,
  input logic [1:0]      cfg_src_b_i,
  input logic [W-1:0]    cfg_reg_a_i,
  input logic [W-1:0]    cfg_reg_b_i,
  input logic [W-1:0]    res_o,
  input logic            res_valid_o
);

  always @(posedge clk_i)
    if (!rst_ni)
      p_reset_r1: assert (res_o == '0 && !res_valid_o) else $error("R1 reset state");

  p_change_on_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(res_o) |-> res_valid_o);

  p_single_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && cfg_div_i != '0) |=> !res_valid_o);

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && $past(cfg_op_i) == 2'b11) |-> res_o == $past(res_o));

  p_add_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && $past(cfg_op_i) == 2'b00 && $past(cfg_src_a_i) == 2'b00
     && $past(cfg_src_b_i) == 2'b00)
    |-> res_o == W'($past(cfg_reg_a_i) + $past(cfg_reg_b_i)));

  p_mul_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && $past(cfg_op_i) == 2'b01 && $past(cfg_src_a_i) == 2'b00
     && $past(cfg_src_b_i) == 2'b00)
    |-> res_o == W'($past(cfg_reg_a_i) * $past(cfg_reg_b_i)));

endmodule

bind mac_tile mac_tile_chk #(.W(W), .DIVW(DIVW)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_div_i   (cfg_div_i),
  .cfg_op_i    (cfg_op_i),
  .cfg_src_a_i (cfg_src_a_i),
  .cfg_src_b_i (cfg_src_b_i),
  .cfg_reg_a_i (cfg_reg_a_i),
  .cfg_reg_b_i (cfg_reg_b_i),
  .res_o       (res_o),
  .res_valid_o (res_valid_o)
);

// File: tb/mac_tile_tb_top.sv
module mac_tile_tb_top;
  localparam int W = 16, NBUS = 3, DIVW = 4, BSELW = 2;
  localparam logic [W-1:0] KA = 16'h00A5, KB = 16'h0003, KC = 16'h0100;

  logic clk = 0, fs_clk = 0, rst_n = 0;
  logic [DIVW-1:0] div = 4'd1;
  logic [1:0] op = 0, sa = 0, sb = 0, sc = 0;
  logic [BSELW-1:0] ba = 0, bb = 0, bc = 0;
  logic [W-1:0] ra = 0, rb = 0, rc = 0, res;
  logic [NBUS*W-1:0] bus = 0;
  logic vld;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  mac_tile #(.W(W), .NBUS(NBUS), .DIVW(DIVW), .BSELW(BSELW), .KA(KA), .KB(KB), .KC(KC)) dut_i (
    .clk_i(clk), .fs_clk_i(fs_clk), .rst_ni(rst_n), .cfg_div_i(div), .cfg_op_i(op),
    .cfg_src_a_i(sa), .cfg_src_b_i(sb), .cfg_src_c_i(sc),
    .cfg_bsel_a_i(ba), .cfg_bsel_b_i(bb), .cfg_bsel_c_i(bc),
    .cfg_reg_a_i(ra), .cfg_reg_b_i(rb), .cfg_reg_c_i(rc),
    .bus_i(bus), .res_o(res), .res_valid_o(vld));

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wait_strobe();
    do @(negedge clk); while (!vld);
  endtask

  function automatic logic [W-1:0] ref_opnd(input logic [1:0] s, input logic [BSELW-1:0] k,
                                             input logic [W-1:0] r, input logic [W-1:0] c,
                                             input logic ph);
    case (s)
      2'b00: return r;
      2'b01: return (k < NBUS) ? bus[k*W +: W] : '0;
      2'b10: return c;
      default: return ph ? ~c : c;
    endcase
  endfunction

  function automatic logic [W-1:0] ref_res(input logic [1:0] o, input logic [W-1:0] a,
                                           input logic [W-1:0] b, input logic [W-1:0] c);
    case (o)
      2'b00: return a + b;
      2'b01: return W'(a * b);
      default: return W'(a * b) + c;
    endcase
  endfunction

  task automatic set_regs(input logic [1:0] o, input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic [W-1:0] c);
    @(negedge clk);
    op = o; sa = 0; sb = 0; sc = 0; ra = a; rb = b; rc = c;
    wait_strobe();
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 res", res, '0);
    check("R1 valid", {15'd0, vld}, 16'd0);
    rst_n = 1;
  endtask

  task automatic t_add();
    set_regs(2'b00, 16'h1234, 16'h4321, 0); check("R2 add", res, 16'h5555);
    set_regs(2'b00, 16'hFFFF, 16'h0001, 0); check("R2 wrap", res, 16'h0000);
  endtask

  task automatic t_mul();
    set_regs(2'b01, 16'h1234, 16'h5678, 0); check("R3 mul", res, 16'h0060);
    set_regs(2'b01, 16'hFFFF, 16'hFFFF, 0); check("R3 max", res, 16'h0001);
  endtask

  task automatic t_mac();
    set_regs(2'b10, 16'h0100, 16'h0100, 16'h0007); check("R4 mac", res, 16'h0007);
    set_regs(2'b10, 16'h0003, 16'h0005, 16'hFFF2); check("R4 wrap", res, 16'h0001);
  endtask

  task automatic t_hold();
    set_regs(2'b00, 16'h0010, 16'h0020, 0);
    @(negedge clk);
    op = 2'b11; ra = 16'hAAAA;
    wait_strobe(); wait_strobe();
    check("R5 hold", res, 16'h0030);
  endtask

  task automatic t_sources();
    for (int i = 0; i < 27; i++) begin
      logic [W-1:0] a, b, c;
      @(negedge clk);
      bus = {$urandom, $urandom};
      ra = W'($urandom); rb = W'($urandom); rc = W'($urandom);
      sa = 2'(i % 3); sb = 2'((i / 3) % 3); sc = 2'(i / 9);
      ba = 2'(i % 3); bb = 2'((i + 1) % 3); bc = 2'((i + 2) % 3);
      op = 2'(i % 3);
      a = ref_opnd(sa, ba, ra, KA, 1'b0);
      b = ref_opnd(sb, bb, rb, KB, 1'b0);
      c = ref_opnd(sc, bc, rc, KC, 1'b0);
      wait_strobe();
      check("R6 source combo", res, ref_res(op, a, b, c));
    end
  endtask

  task automatic t_badbus();
    @(negedge clk);
    op = 2'b00; sa = 2'b01; ba = 2'd3; sb = 2'b00; rb = 16'h0BEE; bus = '1;
    wait_strobe();
    check("R9 missing bus", res, 16'h0BEE);
  endtask

  task automatic fs_pulse();
    @(negedge clk); fs_clk = 1;
    repeat (3) @(negedge clk); fs_clk = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_toggle();
    @(negedge clk);
    op = 2'b00; sa = 2'b11; sb = 2'b00; rb = 0;
    wait_strobe(); check("R7 phase after reset", res, KA);
    fs_pulse(); wait_strobe(); check("R7 inverted", res, ~KA);
    fs_pulse(); wait_strobe(); check("R7 restored", res, KA);
  endtask

  task automatic t_div();
    int n;
    @(negedge clk); div = 4'd3;
    wait_strobe(); wait_strobe();
    n = 0; do begin @(negedge clk); n++; end while (!vld);
    check("R8 period d=3", W'(n), 16'd4);
    @(negedge clk); div = 4'd0;
    wait_strobe(); @(negedge clk);
    check("R8 period d=0", {15'd0, vld}, 16'd1);
    @(negedge clk); div = 4'd6;
    wait_strobe();
    n = 0; do begin @(negedge clk); n++; end while (!vld);
    check("R8 period d=6", W'(n), 16'd7);
    div = 4'd1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_add();
    t_mul();
    t_mac();
    t_hold();
    t_sources();
    t_badbus();
    t_toggle();
    t_div();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule